// File: doc/BRIEF.md
# Device Interrupt Pin Route Registers

This block holds a small little-endian register window through which software assigns each interrupt pin (INTA to INTD) of the devices in slots 25 to 31 to one of eight shared interrupt lines, numbered 0 to 7 (lines A to H). Each slot with a register has its own 32-bit location. The low 16 bits hold four 4-bit pin fields. Every slot from 0 to 31, with or without a register, can be asked combinationally which line a given pin drives.

Slot 30 has no programmable register. Its location always reads zero and its pins are wired to lines 4 to 7. Slots without a register use a rotating spread over lines 4 to 7 and never touch lines 0 to 3.

Accesses are one, two or four bytes wide. The address is reduced to the window size. An access that runs past the window end is cut short at the end and does not wrap. Every write, whatever it hits, raises a one-cycle route-change pulse so that users of the lookup can refresh their state.

Top module: `pirq_route_regs`

## Requirements
- R1: After reset, each slot's register in slots 25 to 29 and 31 reads 32'h0000_3210, so pin n maps to line n. The control word at byte offset 0x20 reads 32'h0000_0022. Every other byte reads zero.
- R2: The register for slot 25+k sits at byte offset 4*k, for k = 0 to 6. Pin n (A=0 to D=3) uses bits [4n+3:4n].
- R3: A value written to a slot's register is seen on the lookup port (lk_dev_i = slot, lk_pin_i = pin, lk_pirq_o = line 0 to 7) from the cycle after the write.
- R4: The slot 30 register, at offset 0x14, always reads zero and ignores writes. Slot 30 pin n always maps to line 4+n.
- R5: A slot without a register (0 to 24) maps pin p to line ((slot + p) mod 4) + 4.
- R6: len_i gives the byte count (1, 2 or 4). Data is little endian: the byte at the access address is carried in bits [7:0]. Bytes outside the access keep their values.
- R7: Only the low 6 address bits are used, so the window is 64 bytes and addresses repeat with period 64.
- R8: If address plus length reaches past byte 63, the access stops at byte 63. Read lanes beyond the end return zero, and write lanes beyond the end change nothing, including the bytes at the window start.
- R9: route_chg_o is high for exactly the one cycle after each accepted write, including writes to slot 30 or to unused bytes. Reads produce no pulse.
- R10: Within a pin field only the low 3 bits select the line. Bit 3 is stored but does not affect the route.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request for the current cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address, reduced to the window |
| len_i | input | 3 | Access length in bytes (1, 2, 4) |
| wdata_i | input | 32 | Write data, little endian |
| rdata_o | output | 32 | Read data, combinational during req_i |
| route_chg_o | output | 1 | One-cycle pulse after each write |
| lk_dev_i | input | 5 | Slot number to look up |
| lk_pin_i | input | 2 | Pin to look up (A=0 to D=3) |
| lk_pirq_o | output | 3 | Interrupt line for the looked-up pin |

## Verification
The assertions assume that len_i is 1, 2 or 4 whenever req_i is high, and that the window is a power of two, so reducing the address cannot overflow the clipping sum. The stimulus uses only those three lengths. It changes every input on the falling clock edge, so requests are stable across the rising edge that accepts them. Lookups and reads are sampled one nanosecond after the inputs change, which keeps the combinational paths away from the active edge.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;
  localparam int unsigned PINS      = 4;
  localparam int unsigned PIRQ_W    = 3;
  localparam int unsigned FIELD_W   = 4;
  localparam int unsigned LANES     = 4;
  localparam int unsigned FIRST_DEV = 25;
  localparam int unsigned NUM_REG   = 7;
  localparam int unsigned FIX_DEV   = 30;
  localparam int unsigned FIX_IDX   = FIX_DEV - FIRST_DEV;
  localparam int unsigned REG_STRIDE = 4;
  localparam int unsigned FIX_OFS   = FIX_IDX * REG_STRIDE;

  typedef logic [PIRQ_W-1:0] pirq_t;
  typedef pirq_t [PINS-1:0] dev_route_t;
endpackage

// File: rtl/route_win_access.sv
module route_win_access #(
  parameter int unsigned WIN_BYTES = 64,
  parameter int unsigned IN_AW     = 16,
  localparam int unsigned WAW      = $clog2(WIN_BYTES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [IN_AW-1:0]    addr_i,
  input  logic [2:0]          len_i,
  output logic [3:0][WAW-1:0] lane_addr_o,
  output logic [3:0]          lane_en_o
);
  logic [WAW-1:0] addr_m;
  logic [WAW:0]   sum, room, eff_len;
  logic           unused_hi;

  assign addr_m    = addr_i[WAW-1:0];
  assign unused_hi = ^addr_i[IN_AW-1:WAW];
  assign sum       = {1'b0, addr_m} + (WAW+1)'(len_i);
  assign room      = (WAW+1)'(WIN_BYTES) - {1'b0, addr_m};
  assign eff_len   = (sum >= (WAW+1)'(WIN_BYTES)) ? room : (WAW+1)'(len_i);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign lane_addr_o[l] = addr_m + WAW'(l);
    assign lane_en_o[l]   = ((WAW+1)'(l) < eff_len);
  end

  // R8
  clip_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && lane_en_o[3] |-> (32'(addr_m) + 32'd3 < 32'(WIN_BYTES)));
endmodule

// File: rtl/route_win_store.sv
module route_win_store
  import pirq_route_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 64,
  parameter logic [15:0] ROUTE_DEF = 16'h3210,
  parameter logic [31:0] GCTL_DEF  = 32'h0000_0022,
  parameter int unsigned GCTL_OFS  = 32,
  localparam int unsigned WAW      = $clog2(WIN_BYTES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [3:0][WAW-1:0]       lane_addr_i,
  input  logic [3:0]                lane_en_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output dev_route_t [NUM_REG-1:0]  route_o
);
  logic [7:0] mem [WIN_BYTES];

  function automatic logic [7:0] rst_byte(int b);
    if (b < int'(NUM_REG * REG_STRIDE) && (b / 4) != int'(FIX_IDX) && (b % 4) < 2)
      return ROUTE_DEF[8*(b%4) +: 8];
    if (b >= int'(GCTL_OFS) && b < int'(GCTL_OFS) + 4)
      return GCTL_DEF[8*(b-int'(GCTL_OFS)) +: 8];
    return 8'h00;
  endfunction

  function automatic logic is_fixed(logic [WAW-1:0] a);
    return (32'(a) >= FIX_OFS) && (32'(a) < FIX_OFS + 4);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < int'(WIN_BYTES); b++) mem[b] <= rst_byte(b);
    end else if (wr_i) begin
      for (int l = 0; l < 4; l++)
        if (lane_en_i[l] && !is_fixed(lane_addr_i[l]))
          mem[lane_addr_i[l]] <= wdata_i[8*l +: 8];
    end
  end

  always_comb begin
    for (int l = 0; l < 4; l++)
      rdata_o[8*l +: 8] = lane_en_i[l] ? mem[lane_addr_i[l]] : 8'h00;
  end

  for (genvar k = 0; k < int'(NUM_REG); k++) begin : g_reg
    for (genvar p = 0; p < int'(PINS); p++) begin : g_pin
      assign route_o[k][p] = mem[k*REG_STRIDE + p/2][FIELD_W*(p%2) +: PIRQ_W];
    end
  end

  // R4
  fixed_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {mem[FIX_OFS], mem[FIX_OFS+1], mem[FIX_OFS+2], mem[FIX_OFS+3]} == 32'h0);
endmodule

// File: rtl/route_map_decode.sv
module route_map_decode
  import pirq_route_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  dev_route_t [NUM_REG-1:0] route_i,
  input  logic [SLOT_W-1:0]        lk_dev_i,
  input  logic [1:0]               lk_pin_i,
  output pirq_t                    lk_pirq_o
);
  pirq_t tab [NUM_SLOTS][PINS];
  logic  unused_fix;

  assign unused_fix = ^route_i[FIX_IDX];

  for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_slot
    for (genvar p = 0; p < int'(PINS); p++) begin : g_pin
      if (s == int'(FIX_DEV)) begin : g_fix
        assign tab[s][p] = PIRQ_W'(p + 4);
      end else if (s >= int'(FIRST_DEV) && s < int'(FIRST_DEV + NUM_REG)) begin : g_prog
        assign tab[s][p] = route_i[s - FIRST_DEV][p];
      end else begin : g_rot
        assign tab[s][p] = PIRQ_W'((s + p) % 4 + 4);
      end
    end
  end

  assign lk_pirq_o = tab[lk_dev_i][lk_pin_i];

  // R4
  fixed_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(lk_dev_i) == FIX_DEV) |-> (lk_pirq_o == {1'b1, lk_pin_i}));
  // R5
  upper_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(lk_dev_i) < FIRST_DEV) |-> lk_pirq_o[PIRQ_W-1]);
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_route_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 64,
  parameter int unsigned IN_AW     = 16,
  parameter int unsigned NUM_SLOTS = 32,
  parameter logic [15:0] ROUTE_DEF = 16'h3210,
  parameter logic [31:0] GCTL_DEF  = 32'h0000_0022,
  parameter int unsigned GCTL_OFS  = 32,
  localparam int unsigned WAW      = $clog2(WIN_BYTES),
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [IN_AW-1:0]  addr_i,
  input  logic [2:0]        len_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              route_chg_o,
  input  logic [SLOT_W-1:0] lk_dev_i,
  input  logic [1:0]        lk_pin_i,
  output logic [2:0]        lk_pirq_o
);
  logic [3:0][WAW-1:0]      lane_addr;
  logic [3:0]               lane_en;
  dev_route_t [NUM_REG-1:0] route;
  logic                     wr;
  logic                     chg_q;

  assign wr = req_i & we_i;

  route_win_access #(.WIN_BYTES(WIN_BYTES), .IN_AW(IN_AW)) i_access (
    .clk_i, .rst_ni, .req_i, .addr_i, .len_i,
    .lane_addr_o(lane_addr), .lane_en_o(lane_en)
  );

  route_win_store #(.WIN_BYTES(WIN_BYTES), .ROUTE_DEF(ROUTE_DEF),
                    .GCTL_DEF(GCTL_DEF), .GCTL_OFS(GCTL_OFS)) i_store (
    .clk_i, .rst_ni, .wr_i(wr), .lane_addr_i(lane_addr), .lane_en_i(lane_en),
    .wdata_i, .rdata_o, .route_o(route)
  );

  route_map_decode #(.NUM_SLOTS(NUM_SLOTS)) i_decode (
    .clk_i, .rst_ni, .route_i(route), .lk_dev_i, .lk_pin_i, .lk_pirq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= 1'b0;
    else         chg_q <= wr;
  end
  assign route_chg_o = chg_q;

  // R9
  chg_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> route_chg_o);
  // R9
  no_chg_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> !route_chg_o);
endmodule

// File: tb/test_pirq_route_regs.sv
`timescale 1ns/1ps
module test_pirq_route_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [2:0]  len = 3'd4;
  logic [31:0] wdata = '0, rdata;
  logic        chg;
  logic [4:0]  lk_dev = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_pirq;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  pirq_route_regs i_pirq_route_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .len_i(len), .wdata_i(wdata), .rdata_o(rdata), .route_chg_o(chg),
    .lk_dev_i(lk_dev), .lk_pin_i(lk_pin), .lk_pirq_o(lk_pirq)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [2:0] n, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; len = n; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    chk("R9 pulse after write", 32'(chg), 32'd1);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'(chg), 32'd0);
  endtask

  task automatic rd(logic [15:0] a, logic [2:0] n, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; len = n;
    #1 d = rdata;
    @(negedge clk);
    req = 0;
    chk("R9 no pulse on read", 32'(chg), 32'd0);
  endtask

  task automatic rd_chk(string r, logic [15:0] a, logic [2:0] n, logic [31:0] exp);
    logic [31:0] d;
    rd(a, n, d);
    chk(r, d, exp);
  endtask

  task automatic lk(string r, int dev, int pin, int exp);
    lk_dev = 5'(dev); lk_pin = 2'(pin);
    #1 chk(r, 32'(lk_pirq), 32'(exp));
  endtask

  task automatic t_reset();
    for (int k = 0; k < 7; k++)
      rd_chk("R1 R2 reg default", 16'(4*k), 3'd4, (k == 5) ? 32'h0 : 32'h0000_3210);
    rd_chk("R1 control default", 16'h20, 3'd4, 32'h0000_0022);
    rd_chk("R1 other zero", 16'h30, 3'd4, 32'h0);
    for (int p = 0; p < 4; p++) lk("R1 default route slot25", 25, p, p);
    lk("R1 default route slot31", 31, 2, 2);
  endtask

  task automatic t_rotate();
    lk("R5 slot0 pinA", 0, 0, 4);
    lk("R5 slot3 pinC", 3, 2, 5);
    lk("R5 slot24 pinD", 24, 3, 7);
    lk("R5 slot10 pinB", 10, 1, 7);
  endtask

  task automatic t_fixed();
    wr(16'h14, 3'd4, 32'hFFFF_FFFF);
    rd_chk("R4 slot30 reg reads zero", 16'h14, 3'd4, 32'h0);
    for (int p = 0; p < 4; p++) lk("R4 slot30 fixed", 30, p, 4 + p);
  endtask

  task automatic t_program();
    wr(16'h08, 3'd2, 32'h0000_7654);
    rd_chk("R3 readback slot27", 16'h08, 3'd4, 32'h0000_7654);
    for (int p = 0; p < 4; p++) lk("R3 slot27 programmed", 27, p, 4 + p);
    lk("R3 slot26 untouched", 26, 1, 1);
  endtask

  task automatic t_bit3();
    wr(16'h0C, 3'd1, 32'h0000_00DA);
    rd_chk("R6 byte write keeps high byte", 16'h0C, 3'd2, 32'h0000_32DA);
    lk("R10 field A low bits", 28, 0, 2);
    lk("R10 field D bit3 ignored", 28, 1, 5);
    lk("R6 pinC kept", 28, 2, 2);
  endtask

  task automatic t_endian();
    wr(16'h24, 3'd4, 32'h1122_3344);
    rd_chk("R6 byte lane", 16'h25, 3'd1, 32'h0000_0033);
    rd_chk("R6 word lane", 16'h26, 3'd2, 32'h0000_1122);
  endtask

  task automatic t_mask();
    wr(16'h1068, 3'd1, 32'h0000_005A);
    rd_chk("R7 masked write", 16'h28, 3'd1, 32'h0000_005A);
    rd_chk("R7 masked read", 16'hFFE8, 3'd1, 32'h0000_005A);
  endtask

  task automatic t_clip();
    wr(16'h3E, 3'd4, 32'hAABB_CCDD);
    rd_chk("R8 clipped write bytes", 16'h3C, 3'd4, 32'hCCDD_0000);
    rd_chk("R8 clipped read lanes", 16'h3E, 3'd4, 32'h0000_CCDD);
    rd_chk("R8 last byte read", 16'h3F, 3'd4, 32'h0000_00CC);
    rd_chk("R8 no wrap", 16'h00, 3'd4, 32'h0000_3210);
  endtask

  task automatic t_rereset();
    do_reset();
    rd_chk("R1 reset clears window", 16'h24, 3'd4, 32'h0);
    lk("R1 reset restores route", 27, 3, 3);
    chk("R9 no pulse after reset", 32'(chg), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    chk("R9 idle after reset", 32'(chg), 32'd0);
    t_reset();
    t_rotate();
    t_fixed();
    t_program();
    t_bit3();
    t_endian();
    t_mask();
    t_clip();
    t_rereset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule